// File: doc/BRIEF.md
# ECC Error Event Counter and Interrupt Unit

This block sits beside an ECC decoder whose returned data word is split into N parts, each checked on its own. On every beat the decoder raises one strobe per part that held a corrected single-bit error and one strobe per part that held an uncorrectable double-bit error. The unit keeps a saturating count for each of the two error classes. When a count update lands exactly on a programmed, nonzero limit, the unit sets a sticky status bit.

A third status bit records a double-bit error that arrives while the controller is in the read phase of a read-modify-write. The write controller marks that phase with `rmw_phase`. Software reaches the control word, the status register, the two limits and the two counts through a small register port. Writes take effect at the clock edge, and reads are combinational. The single interrupt line is the OR of every status bit that the control word does not mask.

Top module: `ecc_err_irq_unit`

## Requirements
- R1: After reset, the control word, status, both limits and both counts read 0, and `irq` is 0.
- R2: On each beat, the single-bit count grows by the number of set bits in `sbe_strobe`, and the double-bit count grows by the number of set bits in `dbe_strobe`. Both changes are visible after the next clock edge.
- R3: A count stops at 2^CNT_W-1 and never wraps.
- R4: Status bit 0 (single-bit class) or status bit 1 (double-bit class) is set when an update changes that count to a value equal to its limit. A limit of 0 never fires. A beat that steps over the limit without landing on it sets nothing.
- R5: Status sits at offset 1. Writing 1 to a bit clears it, and writing 0 has no effect. A bit stays set until it is cleared. If a set event and a clearing write occur in the same cycle, the bit ends up set.
- R6: Control bits 0, 1 and 2 mask status bits 0, 1 and 2 from `irq`, where 1 means masked. `irq` is the OR of the unmasked status bits. Masking does not alter status.
- R7: A beat with `rmw_phase` high and any `dbe_strobe` bit set sets status bit 2. Double-bit errors outside that phase leave bit 2 untouched.
- R8: Writing 1 to control bit 3 zeroes both counts. Events in that same cycle are discarded. Bit 3 always reads back as 0.
- R9: The register map is: control at offset 0, status at 1, single-bit limit at 2, double-bit limit at 3, single-bit count at 4 and double-bit count at 5. Counts are read-only, so writes to offsets 4 and 5 are ignored. Offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sbe_strobe | input | N_PARTS | Per-part correctable error flags for this beat |
| dbe_strobe | input | N_PARTS | Per-part uncorrectable error flags for this beat |
| rmw_phase | input | 1 | Beat belongs to the read phase of a read-modify-write |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data, combinational on `reg_addr` |
| irq | output | 1 | Interrupt, the OR of unmasked status bits |

## Verification
The hardest condition to reach from the ports is a set event and a clearing write landing in the same cycle. The stimulus handles this by raising an error strobe and a status write of 1 on the same falling edge. A similar case is a counter-clear write that coincides with an error beat. The saturation limit needs many multi-part beats, so the bench drives all-parts-failing beats until the count would pass its maximum. It puts the limit at that maximum, which checks that the equality hit still fires on the clamped value.

// File: rtl/ecc_irq_pkg.sv
// Package: register offsets and bit positions shared by the error-interrupt unit.
// Assumes a 3-bit register offset space.
package ecc_irq_pkg;
    localparam int ADDR_W    = 3;
    localparam int N_STATUS  = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_THR_SBE = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_THR_DBE = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_CNT_SBE = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_CNT_DBE = 3'd5;

    // Status and mask bit positions (mask bit k guards status bit k)
    localparam int ST_SBE = 0;
    localparam int ST_DBE = 1;
    localparam int ST_RMW = 2;
    // Control bit that zeroes both counters (self-clearing)
    localparam int CTL_CLR = 3;
endpackage

// File: rtl/ecc_event_sum.sv
// Module: counts how many per-part strobes are set in one beat.
// Assumes strobes are already aligned to one beat per clock.
module ecc_event_sum #(
    parameter int N_PARTS = 4,
    localparam int SUM_W  = $clog2(N_PARTS + 1)
) (
    input  logic [N_PARTS-1:0] strobe_i,
    output logic [SUM_W-1:0]   sum_o
);
    // Population count of the strobe vector
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < N_PARTS; i++) begin
            sum_o = sum_o + SUM_W'(strobe_i[i]);
        end
    end
endmodule

// File: rtl/ecc_sat_counter.sv
// Module: saturating event counter with equality hit against a limit.
// Assumes inc_i is at most N_PARTS per cycle; clr_i beats any increment.
module ecc_sat_counter #(
    parameter int CNT_W = 8,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [INC_W-1:0] inc_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    localparam logic [CNT_W:0] MAX_W = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W:0]   sum_w;

    // Next count: clear first, else clamp the widened sum
    always_comb begin
        sum_w = {1'b0, cnt_q} + {{(CNT_W + 1 - INC_W){1'b0}}, inc_i};
        if (clr_i)
            cnt_d = '0;
        else if (sum_w > MAX_W)
            cnt_d = MAX_W[CNT_W-1:0];
        else
            cnt_d = sum_w[CNT_W-1:0];
    end

    // Hit when the value moves onto a nonzero limit
    assign hit_o = !clr_i && (cnt_d != cnt_q) && (cnt_d == thr_i) && (thr_i != '0);

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R3: a saturated counter stays saturated unless cleared
    a_r3_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAX_W[CNT_W-1:0] && !clr_i) |=> (cnt_q == MAX_W[CNT_W-1:0]));
    // R2: without a clear the count never goes down
    a_r2_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q >= $past(cnt_q)));
    // R8: a clear leaves zero on the next cycle
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/ecc_irq_status.sv
// Module: sticky status bits, write-one-to-clear, set beats clear.
// Assumes w1c_i is already qualified by a write to the status offset.
module ecc_irq_status #(
    parameter int NB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_i,
    input  logic [NB-1:0] w1c_i,
    output logic [NB-1:0] st_o
);
    logic [NB-1:0] st_q;

    // Keep, clear on write-one, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~w1c_i) | set_i;
    end

    assign st_o = st_q;

    // R5: any set event shows up next cycle, even against a clearing write
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & $past(set_i)) == $past(set_i)));
    // R5: a set bit without a clearing write stays set
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & $past(st_q & ~w1c_i)) == $past(st_q & ~w1c_i)));
endmodule

// File: rtl/ecc_err_irq_unit.sv
// Module: top of the ECC error counter and interrupt unit.
// Counts single/double-bit events over N parts per beat, raises maskable
// sticky status on threshold equality and on a double-bit error during the
// read phase of a read-modify-write. Assumes CNT_W >= 4 for the control word.
module ecc_err_irq_unit
    import ecc_irq_pkg::*;
#(
    parameter int N_PARTS = 4,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PARTS-1:0] sbe_strobe,
    input  logic [N_PARTS-1:0] dbe_strobe,
    input  logic               rmw_phase,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    output logic               irq
);
    localparam int SUM_W = $clog2(N_PARTS + 1);
    localparam int N_CLS = 2;

    logic [N_CLS-1:0][N_PARTS-1:0] strb;
    logic [N_CLS-1:0][SUM_W-1:0]   sum;
    logic [N_CLS-1:0][CNT_W-1:0]   cnt;
    logic [N_CLS-1:0][CNT_W-1:0]   thr_q;
    logic [N_CLS-1:0]              hit;
    logic [N_STATUS-1:0]           mask_q;
    logic [N_STATUS-1:0]           status;
    logic [N_STATUS-1:0]           st_set;
    logic [N_STATUS-1:0]           st_w1c;
    logic                          cnt_clr;
    logic                          wr_ctrl;

    assign strb[0] = sbe_strobe;
    assign strb[1] = dbe_strobe;
    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    assign cnt_clr = wr_ctrl && reg_wdata[CTL_CLR];

    // One event adder and one counter per error class
    for (genvar g = 0; g < N_CLS; g++) begin : g_cls
        ecc_event_sum #(.N_PARTS(N_PARTS)) u_sum (
            .strobe_i (strb[g]),
            .sum_o    (sum[g])
        );
        ecc_sat_counter #(.CNT_W(CNT_W), .INC_W(SUM_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (cnt_clr),
            .inc_i (sum[g]),
            .thr_i (thr_q[g]),
            .cnt_o (cnt[g]),
            .hit_o (hit[g])
        );
    end

    // Control mask and threshold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            thr_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_CTRL:    mask_q   <= reg_wdata[N_STATUS-1:0];
                OFS_THR_SBE: thr_q[0] <= reg_wdata;
                OFS_THR_DBE: thr_q[1] <= reg_wdata;
                default:     ;
            endcase
        end
    end

    assign st_set[ST_SBE] = hit[0];
    assign st_set[ST_DBE] = hit[1];
    assign st_set[ST_RMW] = rmw_phase && (|dbe_strobe);
    assign st_w1c = (reg_wr && reg_addr == OFS_STATUS) ? reg_wdata[N_STATUS-1:0] : '0;

    ecc_irq_status #(.NB(N_STATUS)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (st_set),
        .w1c_i (st_w1c),
        .st_o  (status)
    );

    // Interrupt: any status bit not masked
    assign irq = |(status & ~mask_q);

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL:    reg_rdata[N_STATUS-1:0] = mask_q;
            OFS_STATUS:  reg_rdata[N_STATUS-1:0] = status;
            OFS_THR_SBE: reg_rdata = thr_q[0];
            OFS_THR_DBE: reg_rdata = thr_q[1];
            OFS_CNT_SBE: reg_rdata = cnt[0];
            OFS_CNT_DBE: reg_rdata = cnt[1];
            default:     reg_rdata = '0;
        endcase
    end

    // R7: a double-bit error in the read phase of an RMW raises its flag
    a_r7_rmw_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw_phase && (|dbe_strobe)) |=> status[ST_RMW]);
    // R1: nothing is pending in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!irq && status == '0));
endmodule

// File: tb/tb_ecc_err_irq_unit.sv
module tb_ecc_err_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N_PARTS = 4;
    localparam int CNT_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N_PARTS-1:0] sbe_strobe = '0;
    logic [N_PARTS-1:0] dbe_strobe = '0;
    logic               rmw_phase = 1'b0;
    logic               reg_wr = 1'b0;
    logic [2:0]         reg_addr = '0;
    logic [CNT_W-1:0]   reg_wdata = '0;
    logic [CNT_W-1:0]   reg_rdata;
    logic               irq;

    int n_checks = 0;
    int n_errors = 0;

    ecc_err_irq_unit #(.N_PARTS(N_PARTS), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .sbe_strobe(sbe_strobe), .dbe_strobe(dbe_strobe),
        .rmw_phase(rmw_phase), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [CNT_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic beat(logic [N_PARTS-1:0] s, logic [N_PARTS-1:0] d, logic rmw);
        @(negedge clk);
        sbe_strobe = s; dbe_strobe = d; rmw_phase = rmw;
        @(negedge clk);
        sbe_strobe = '0; dbe_strobe = '0; rmw_phase = 1'b0;
    endtask

    task automatic clean();
        wr(3'd0, 8'h08);
        wr(3'd1, 8'h07);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 reg after reset", v, 0);
        end
        check("R1 irq after reset", int'(irq), 0);
    endtask

    task automatic t_count();
        int v;
        clean();
        beat(4'b1011, 4'b0000, 1'b0);
        rd(3'd4, v); check("R2 sbe count 3 parts", v, 3);
        beat(4'b0000, 4'b0110, 1'b0);
        rd(3'd5, v); check("R2 dbe count 2 parts", v, 2);
        beat(4'b0001, 4'b1000, 1'b0);
        rd(3'd4, v); check("R2 sbe count accum", v, 4);
        rd(3'd5, v); check("R2 dbe count accum", v, 3);
        wr(3'd0, 8'h08);
        rd(3'd4, v); check("R8 sbe cleared", v, 0);
        rd(3'd5, v); check("R8 dbe cleared", v, 0);
        rd(3'd0, v); check("R8 clear bit reads 0", v, 0);
    endtask

    task automatic t_threshold();
        int v;
        clean();
        wr(3'd2, 8'd5);
        beat(4'b0011, 4'b0000, 1'b0);
        rd(3'd1, v); check("R4 below limit", v, 0);
        beat(4'b0111, 4'b0000, 1'b0);
        rd(3'd1, v); check("R4 equal limit sets bit0", v, 1);
        check("R6 irq on unmasked", int'(irq), 1);
        beat(4'b0001, 4'b0000, 1'b0);
        rd(3'd1, v); check("R5 sticky", v, 1);
        wr(3'd1, 8'h00);
        rd(3'd1, v); check("R5 write 0 no effect", v, 1);
        wr(3'd1, 8'h01);
        rd(3'd1, v); check("R5 w1c clears", v, 0);
        check("R6 irq drops", int'(irq), 0);
    endtask

    task automatic t_jump();
        int v;
        clean();
        wr(3'd2, 8'd3);
        beat(4'b1111, 4'b0000, 1'b0);
        rd(3'd1, v); check("R4 step over limit", v, 0);
        wr(3'd3, 8'd0);
        beat(4'b0000, 4'b0001, 1'b0);
        rd(3'd1, v); check("R4 zero limit never fires", v, 0);
    endtask

    task automatic t_mask();
        int v;
        clean();
        wr(3'd3, 8'd2);
        wr(3'd0, 8'h02);
        beat(4'b0000, 4'b0011, 1'b0);
        rd(3'd1, v); check("R6 masked status still set", v, 2);
        check("R6 masked irq low", int'(irq), 0);
        wr(3'd0, 8'h00);
        check("R6 unmask raises irq", int'(irq), 1);
    endtask

    task automatic t_set_wins();
        int v;
        clean();
        wr(3'd2, 8'd1);
        @(negedge clk);
        sbe_strobe = 4'b0001; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h01;
        @(negedge clk);
        sbe_strobe = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(3'd1, v); check("R5 set wins over clear", v, 1);
    endtask

    task automatic t_rmw();
        int v;
        clean();
        beat(4'b0000, 4'b0001, 1'b0);
        rd(3'd1, v); check("R7 dbe outside rmw", v, 0);
        beat(4'b0000, 4'b0100, 1'b1);
        rd(3'd1, v); check("R7 dbe in rmw sets bit2", v, 4);
        rd(3'd5, v); check("R7 rmw dbe still counted", v, 2);
        check("R7 irq from rmw flag", int'(irq), 1);
        wr(3'd0, 8'h04);
        check("R6 rmw flag masked", int'(irq), 0);
        beat(4'b0000, 4'b0000, 1'b1);
        rd(3'd1, v); check("R7 rmw without dbe no change", v, 4);
    endtask

    task automatic t_saturate();
        int v;
        clean();
        wr(3'd2, 8'd255);
        for (int i = 0; i < 63; i++) beat(4'b1111, 4'b0000, 1'b0);
        rd(3'd4, v); check("R2 count 252", v, 252);
        rd(3'd1, v); check("R4 not yet at limit", v, 0);
        beat(4'b1111, 4'b0000, 1'b0);
        rd(3'd4, v); check("R3 saturates", v, 255);
        rd(3'd1, v); check("R4 hit on clamped max", v, 1);
        beat(4'b1111, 4'b0000, 1'b0);
        rd(3'd4, v); check("R3 stays at max", v, 255);
    endtask

    task automatic t_clear_vs_event();
        int v;
        clean();
        beat(4'b0011, 4'b0001, 1'b0);
        @(negedge clk);
        sbe_strobe = 4'b1111; dbe_strobe = 4'b1111;
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h09;
        @(negedge clk);
        sbe_strobe = '0; dbe_strobe = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(3'd4, v); check("R8 clear discards events", v, 0);
        rd(3'd5, v); check("R8 clear discards dbe", v, 0);
        rd(3'd0, v); check("R8 mask kept, bit3 reads 0", v, 1);
    endtask

    task automatic t_map();
        int v;
        clean();
        beat(4'b0001, 4'b0011, 1'b0);
        wr(3'd4, 8'h55);
        wr(3'd5, 8'h55);
        rd(3'd4, v); check("R9 count4 read-only", v, 1);
        rd(3'd5, v); check("R9 count5 read-only", v, 2);
        wr(3'd2, 8'hA5);
        wr(3'd3, 8'h3C);
        rd(3'd2, v); check("R9 limit at 2", v, 165);
        rd(3'd3, v); check("R9 limit at 3", v, 60);
        rd(3'd6, v); check("R9 offset 6 reads 0", v, 0);
        rd(3'd7, v); check("R9 offset 7 reads 0", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_threshold();
        t_jump();
        t_mask();
        t_set_wins();
        t_rmw();
        t_saturate();
        t_clear_vs_event();
        t_map();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule